// File: doc/BRIEF.md
# External bus chip-select controller

This block sits between an internal requester and an external bus carrying SRAM-style devices. It turns each 32-bit request into one or more strobed transfers on the external pins. The request address is decoded onto one of six active-low chip selects. Two selects own large 128 MB windows. The other four own 32 MB windows. A combine setting folds the two large windows into a single 256 MB region driven by the first select.

Each select has its own settings, held in registers written through a small configuration port:
- a write-protect flag,
- a data port width of 8, 16 or 32 bits,
- a 4-bit wait-state count.

A word access to a narrower port is split into sequential beats, and each beat holds its strobe for the wait-state count plus one cycle. The requester picks the byte order for every access. The settings are captured when a request is accepted, so a later configuration write cannot disturb a transfer already under way.

Top module: `xbus_csel`

## Requirements
- R1: The address map is contiguous. Select 0 decodes 0x0000000-0x7FFFFFF and select 1 decodes 0x8000000-0xFFFFFFF. Selects 2 to 5 each decode 32 MB, starting at 0x10000000 in ascending order. The address driven on ext_addr is the word-aligned offset inside the window.
- R2: A request at 0x18000000 or above completes with resp_err high and drives no chip select and no strobe.
- R3: When the combine bit is 1, any address in either large window selects select 0. The offset then runs across the whole 256 MB, and the access uses the settings of select 0.
- R4: A write to a select whose protect bit is set completes with resp_err high and drives no strobe. A read of the same select proceeds normally.
- R5: Width code 0 is an 8-bit port and gives 4 beats. Code 1 is a 16-bit port and gives 2 beats. Codes 2 and 3 are a 32-bit port and give 1 beat. Each beat advances ext_addr by the port width in bytes.
- R6: Each beat holds the strobe for exactly W+1 cycles, where W is the select's wait-state count. resp_valid rises on the cycle after the last strobe cycle.
- R7: Let byte k of the word be bits 8k+7:8k. Little-endian maps byte k to external address offset+k. Big-endian maps byte 3-k to offset+k. External lane j carries the byte at the beat address plus j.
- R8: Read data is assembled from the lanes with the same mapping as R7 and is returned on resp_rdata with resp_err low.
- R9: cs_n, oe_n and we_n are active low. At most one chip select is low in any cycle. oe_n and we_n are never low together. A strobe is low exactly when a chip select is low.
- R10: Settings are taken when the request is accepted. A configuration write during a transfer leaves that transfer's beats and timing unchanged and takes effect from the next request.
- R11: During and after reset, every chip select, oe_n and we_n is high, req_ready is high and resp_valid is low. Each select starts unprotected, 32 bits wide and with 0 wait states, and combine starts at 0.
- R12: req_ready is low while a transfer is on the bus. An error response drives no select.
- R13: The configuration port writes select n's settings at cfg_addr n (0 to 5). In cfg_wdata, bit 6 is protect, bits 5:4 are the width code and bits 3:0 are the wait count. cfg_addr 6 writes combine from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_big_end | input | 1 | 1 = big-endian byte order for this access |
| req_addr | input | 29 | Internal byte address |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle completion flag |
| resp_err | output | 1 | Completion was blocked (unmapped or protected) |
| resp_rdata | output | 32 | Read word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 7 | Configuration write data |
| cs_n | output | 6 | Chip selects, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ext_addr | output | 28 | External byte address within the window |
| ext_dout | output | 32 | External write lanes |
| ext_din | input | 32 | External read lanes |

## Verification
The assertions take for granted that req_valid only counts while req_ready is high. They also assume that configuration writes never share a clock edge with a request acceptance, since decoding uses the settings registered before that edge. The stimulus raises req_valid only on a cycle where req_ready was seen high, and drops it one cycle later. Configuration writes are issued from the same sequential flow as requests, so they never line up with an acceptance edge. The only configuration write made during a transfer is issued after the accept edge, which is exactly the case R10 covers.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int BYTES  = 4;
    localparam int DATA_W = 8 * BYTES;
    localparam int WS_W   = 4;

    typedef enum logic [1:0] {
        PW_8    = 2'd0,
        PW_16   = 2'd1,
        PW_32   = 2'd2,
        PW_32B  = 2'd3
    } port_w_e;

    typedef struct packed {
        logic            wprot;
        port_w_e         width;
        logic [WS_W-1:0] wait_st;
    } cs_cfg_t;

    localparam int CFG_W = $bits(cs_cfg_t);

    localparam cs_cfg_t CFG_RESET = '{wprot: 1'b0, width: PW_32, wait_st: '0};

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STROBE = 1'b1
    } bus_st_e;

    // Bytes carried by one beat on a port of the given width.
    function automatic logic [2:0] port_bytes(port_w_e w);
        case (w)
            PW_8:    return 3'd1;
            PW_16:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Index of the final beat of a word access.
    function automatic logic [1:0] last_beat(port_w_e w);
        case (w)
            PW_8:    return 2'd3;
            PW_16:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
    import xbus_pkg::*;
#(
    parameter int N_CS  = 6,
    parameter int SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    output cs_cfg_t [N_CS-1:0]    cfg_q,
    output logic                  combine_q
);

    for (genvar g = 0; g < N_CS; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= CFG_RESET;
            end else if (cfg_we && cfg_addr == SEL_W'(g)) begin
                cfg_q[g] <= cs_cfg_t'(cfg_wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            combine_q <= 1'b0;
        end else if (cfg_we && cfg_addr == SEL_W'(N_CS)) begin
            combine_q <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/xbus_addr_decode.sv
module xbus_addr_decode #(
    parameter int ADDR_W   = 29,
    parameter int LARGE_AW = 27,
    parameter int SMALL_AW = 25,
    parameter int N_LARGE  = 2,
    parameter int N_SMALL  = 4,
    parameter int N_CS     = N_LARGE + N_SMALL,
    parameter int IDX_W    = 3,
    parameter int EXT_AW   = LARGE_AW + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              combine,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [EXT_AW-1:0] offset
);

    localparam logic [ADDR_W:0] SMALL_BASE = (ADDR_W+1)'(N_LARGE) << LARGE_AW;

    logic [ADDR_W:0]   addr_x;
    logic [N_CS-1:0]   win_hit;
    logic [EXT_AW-1:0] win_off [N_CS];

    assign addr_x = {1'b0, addr};

    for (genvar g = 0; g < N_CS; g++) begin : g_win
        if (g < N_LARGE) begin : g_large
            assign win_hit[g] = (addr_x >> LARGE_AW) == (ADDR_W+1)'(g);
            assign win_off[g] = EXT_AW'(addr[LARGE_AW-1:0]);
        end else begin : g_small
            localparam logic [ADDR_W:0] BASE  = SMALL_BASE + ((ADDR_W+1)'(g - N_LARGE) << SMALL_AW);
            localparam logic [ADDR_W:0] LIMIT = BASE + ((ADDR_W+1)'(1) << SMALL_AW);
            assign win_hit[g] = (addr_x >= BASE) && (addr_x < LIMIT);
            assign win_off[g] = EXT_AW'(addr[SMALL_AW-1:0]);
        end
    end

    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        offset = '0;
        for (int i = 0; i < N_CS; i++) begin
            if (win_hit[i]) begin
                hit    = 1'b1;
                idx    = IDX_W'(i);
                offset = win_off[i];
            end
        end
        // Merged region: both large windows answer on the first select.
        if (combine && (win_hit[0] || win_hit[1])) begin
            idx    = '0;
            offset = EXT_AW'(addr[LARGE_AW:0]);
        end
    end

endmodule

// File: rtl/xbus_lane_map.sv
module xbus_lane_map
    import xbus_pkg::*;
(
    input  logic              big_end,
    input  port_w_e           width,
    input  logic [1:0]        beat,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rdata_q,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rdata_d
);

    logic [1:0] pos;
    logic [1:0] wsel;

    always_comb begin
        dout    = '0;
        rdata_d = rdata_q;
        pos     = '0;
        wsel    = '0;
        for (int j = 0; j < BYTES; j++) begin
            if (j < int'(port_bytes(width))) begin
                pos  = 2'(int'(beat) * int'(port_bytes(width)) + j);
                wsel = big_end ? (2'd3 - pos) : pos;
                dout[8*j +: 8]       = wdata[8*wsel +: 8];
                rdata_d[8*wsel +: 8] = din[8*j +: 8];
            end
        end
    end

endmodule

// File: rtl/xbus_csel.sv
module xbus_csel
    import xbus_pkg::*;
#(
    parameter int ADDR_W   = 29,
    parameter int LARGE_AW = 27,
    parameter int SMALL_AW = 25,
    parameter int N_LARGE  = 2,
    parameter int N_SMALL  = 4,
    localparam int N_CS    = N_LARGE + N_SMALL,
    localparam int IDX_W   = $clog2(N_CS),
    localparam int SEL_W   = $clog2(N_CS + 1),
    localparam int EXT_AW  = LARGE_AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_big_end,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              resp_valid,
    output logic              resp_err,
    output logic [31:0]       resp_rdata,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [6:0]        cfg_wdata,
    output logic [N_CS-1:0]   cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [31:0]       ext_dout,
    input  logic [31:0]       ext_din
);

    typedef struct packed {
        logic              write;
        logic              big_end;
        logic [IDX_W-1:0]  idx;
        logic [EXT_AW-1:0] base;
        logic [DATA_W-1:0] wdata;
        port_w_e           width;
        logic [WS_W-1:0]   ws;
    } xfer_t;

    cs_cfg_t [N_CS-1:0] cfg_q;
    logic               combine_q;

    logic               dec_hit;
    logic [IDX_W-1:0]   dec_idx;
    logic [EXT_AW-1:0]  dec_off;
    cs_cfg_t            sel_cfg;
    logic               blocked;
    logic               accept;

    bus_st_e            st_q;
    xfer_t              cur_q;
    logic [1:0]         beat_q;
    logic [WS_W-1:0]    wait_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rdata_d;
    logic [DATA_W-1:0]  lane_dout;
    logic [2:0]         beat_off;

    xbus_cfg_regs #(.N_CS(N_CS), .SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .combine_q (combine_q)
    );

    xbus_addr_decode #(
        .ADDR_W   (ADDR_W),
        .LARGE_AW (LARGE_AW),
        .SMALL_AW (SMALL_AW),
        .N_LARGE  (N_LARGE),
        .N_SMALL  (N_SMALL),
        .N_CS     (N_CS),
        .IDX_W    (IDX_W),
        .EXT_AW   (EXT_AW)
    ) u_dec (
        .addr    (req_addr),
        .combine (combine_q),
        .hit     (dec_hit),
        .idx     (dec_idx),
        .offset  (dec_off)
    );

    xbus_lane_map u_lanes (
        .big_end (cur_q.big_end),
        .width   (cur_q.width),
        .beat    (beat_q),
        .wdata   (cur_q.wdata),
        .din     (ext_din),
        .rdata_q (rdata_q),
        .dout    (lane_dout),
        .rdata_d (rdata_d)
    );

    assign sel_cfg   = cfg_q[dec_idx];
    assign blocked   = !dec_hit || (req_write && sel_cfg.wprot);
    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cur_q      <= '0;
            beat_q     <= '0;
            wait_q     <= '0;
            rdata_q    <= '0;
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (blocked) begin
                            resp_valid <= 1'b1;
                            resp_err   <= 1'b1;
                            resp_rdata <= '0;
                        end else begin
                            st_q          <= ST_STROBE;
                            cur_q.write   <= req_write;
                            cur_q.big_end <= req_big_end;
                            cur_q.idx     <= dec_idx;
                            cur_q.base    <= dec_off & ~EXT_AW'(3);
                            cur_q.wdata   <= req_wdata;
                            cur_q.width   <= sel_cfg.width;
                            cur_q.ws      <= sel_cfg.wait_st;
                            beat_q        <= '0;
                            wait_q        <= sel_cfg.wait_st;
                            rdata_q       <= '0;
                        end
                    end
                end
                ST_STROBE: begin
                    if (wait_q != '0) begin
                        wait_q <= wait_q - 1'b1;
                    end else begin
                        if (!cur_q.write) begin
                            rdata_q <= rdata_d;
                        end
                        if (beat_q == last_beat(cur_q.width)) begin
                            st_q       <= ST_IDLE;
                            resp_valid <= 1'b1;
                            resp_err   <= 1'b0;
                            resp_rdata <= cur_q.write ? '0 : rdata_d;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                            wait_q <= cur_q.ws;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (cur_q.width)
            PW_8:    beat_off = {1'b0, beat_q};
            PW_16:   beat_off = {beat_q, 1'b0};
            default: beat_off = 3'd0;
        endcase
    end

    for (genvar g = 0; g < N_CS; g++) begin : g_cs
        assign cs_n[g] = !((st_q == ST_STROBE) && (cur_q.idx == IDX_W'(g)));
    end

    assign oe_n     = !((st_q == ST_STROBE) && !cur_q.write);
    assign we_n     = !((st_q == ST_STROBE) && cur_q.write);
    assign ext_addr = cur_q.base + EXT_AW'(beat_off);
    assign ext_dout = ((st_q == ST_STROBE) && cur_q.write) ? lane_dout : '0;

endmodule

// File: rtl/xbus_csel_chk.sv
module xbus_csel_chk #(
    parameter int N_CS = 6
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CS-1:0] cs_n,
    input logic            oe_n,
    input logic            we_n,
    input logic            req_ready,
    input logic            resp_valid,
    input logic            resp_err
);

    // R9
    one_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    // R9
    strobe_with_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || !we_n) == (cs_n != '1));

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n != '1) |-> !req_ready);

    // R2
    err_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> (cs_n == '1 && oe_n && we_n));

    // R10
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n != '1 && $past(cs_n) != '1) |-> $stable(cs_n));

endmodule

bind xbus_csel xbus_csel_chk #(.N_CS(N_CS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_err   (resp_err)
);

// File: tb/xbus_csel_bench.sv
module xbus_csel_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_big_end = 1'b0;
    logic [28:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic        resp_err;
    logic [31:0] resp_rdata;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [6:0]  cfg_wdata = '0;
    logic [5:0]  cs_n;
    logic        oe_n;
    logic        we_n;
    logic [27:0] ext_addr;
    logic [31:0] ext_dout;
    logic [31:0] ext_din;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_csel u_xbus_csel (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_big_end(req_big_end), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din)
    );

    // External device model: each byte address returns a fixed pattern.
    function automatic logic [7:0] dev_byte(logic [27:0] a);
        return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h3C;
    endfunction

    always_comb begin
        for (int j = 0; j < 4; j++) ext_din[8*j +: 8] = dev_byte(ext_addr + 28'(j));
    end

    typedef struct {
        bit          err;
        bit          write;
        bit          big;
        logic [31:0] wdata;
        logic [31:0] rdata;
        int          cs;
        int          cycles;
        int          pb;
        logic [27:0] off;
        string       req;
    } exp_t;

    exp_t sb[$];

    // Bench copy of programmed settings
    int m_width [6];
    int m_ws    [6];
    bit m_prot  [6];
    bit m_comb;

    task automatic chk(input bit ok, input string r, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input bit prot, input int width, input int ws);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(sel);
        cfg_wdata = {prot, 2'(width), 4'(ws)};
        @(negedge clk);
        cfg_we    = 1'b0;
        m_prot[sel]  = prot;
        m_width[sel] = width;
        m_ws[sel]    = ws;
    endtask

    task automatic cfg_combine(input bit c);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 3'd6;
        cfg_wdata = {6'd0, c};
        @(negedge clk);
        cfg_we    = 1'b0;
        m_comb    = c;
    endtask

    task automatic access(input bit wr, input bit big, input logic [28:0] addr,
                          input logic [31:0] wd, input string r);
        exp_t e;
        int   cs;
        logic [27:0] off;
        if (addr < 29'h1000_0000) begin
            cs  = int'(addr >> 27);
            off = 28'(addr & 29'h07FF_FFFF);
            if (m_comb) begin
                cs  = 0;
                off = addr[27:0];
            end
        end else if (addr < 29'h1800_0000) begin
            cs  = 2 + int'((addr - 29'h1000_0000) >> 25);
            off = 28'(addr & 29'h01FF_FFFF);
        end else begin
            cs  = -1;
            off = '0;
        end
        off     = off & ~28'd3;
        e.err   = (cs < 0) || (wr && m_prot[cs]);
        e.write = wr;
        e.big   = big;
        e.wdata = wd;
        e.cs    = e.err ? -1 : cs;
        e.off   = off;
        e.req   = r;
        e.pb    = 4;
        e.cycles = 0;
        if (!e.err) begin
            e.pb = (m_width[cs] == 0) ? 1 : (m_width[cs] == 1) ? 2 : 4;
            e.cycles = (4 / e.pb) * (m_ws[cs] + 1);
        end
        e.rdata = '0;
        if (!wr && !e.err) begin
            for (int i = 0; i < 4; i++) begin
                if (big) e.rdata[8*(3-i) +: 8] = dev_byte(off + 28'(i));
                else     e.rdata[8*i +: 8]     = dev_byte(off + 28'(i));
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sb.push_back(e);
        req_valid   = 1'b1;
        req_write   = wr;
        req_big_end = big;
        req_addr    = addr;
        req_wdata   = wd;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    // Monitor: accumulates bus activity and scores it at each response.
    int          mon_strobes = 0;
    int          mon_cs = -1;
    bit          mon_first = 1;
    bit          mon_badcs = 0;
    logic [27:0] mon_addr0 = '0;
    logic [7:0]  mon_wb [4];

    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n != '1) begin
                int c;
                int rel;
                c = -1;
                for (int j = 0; j < 6; j++) if (!cs_n[j]) c = j;
                if (mon_first) begin
                    mon_addr0 = ext_addr;
                    mon_cs    = c;
                    mon_first = 0;
                end else if (c != mon_cs) begin
                    mon_badcs = 1;
                end
                mon_strobes++;
                if (!we_n && sb.size() > 0) begin
                    for (int j = 0; j < sb[0].pb; j++) begin
                        rel = int'(ext_addr - mon_addr0) + j;
                        if (rel >= 0 && rel < 4) mon_wb[rel] = ext_dout[8*j +: 8];
                    end
                end
            end
            if (resp_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R12", "response with nothing pending", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(resp_err == e.err, e.req, "resp_err", 64'(resp_err), 64'(e.err));
                    chk(mon_cs == e.cs && !mon_badcs, e.req, "chip select",
                        64'(mon_cs), 64'(e.cs));
                    chk(mon_strobes == e.cycles, e.req, "strobe cycles",
                        64'(mon_strobes), 64'(e.cycles));
                    if (!e.err) begin
                        chk(mon_addr0 == e.off, e.req, "first ext_addr",
                            64'(mon_addr0), 64'(e.off));
                        if (e.write) begin
                            for (int i = 0; i < 4; i++) begin
                                logic [7:0] x;
                                x = e.big ? e.wdata[8*(3-i) +: 8] : e.wdata[8*i +: 8];
                                chk(mon_wb[i] === x, e.req, "written byte",
                                    64'(mon_wb[i]), 64'(x));
                            end
                        end else begin
                            chk(resp_rdata == e.rdata, e.req, "resp_rdata",
                                64'(resp_rdata), 64'(e.rdata));
                        end
                    end
                end
                mon_strobes = 0;
                mon_cs      = -1;
                mon_first   = 1;
                mon_badcs   = 0;
                for (int i = 0; i < 4; i++) mon_wb[i] = 'x;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            m_width[i] = 2; m_ws[i] = 0; m_prot[i] = 0;
        end
        m_comb = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(cs_n == 6'h3F, "R11", "cs_n in reset", 64'(cs_n), 64'h3F);
        chk(oe_n && we_n, "R11", "strobes in reset", 64'({oe_n, we_n}), 64'h3);
        chk(req_ready == 1'b1, "R11", "req_ready in reset", 64'(req_ready), 1);
        chk(resp_valid == 1'b0, "R11", "resp_valid in reset", 64'(resp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 6'h3F && oe_n && we_n, "R11", "idle after reset",
            64'({cs_n, oe_n, we_n}), 64'hFF);

        // R11 default settings, R1 window 0 and R8 read
        access(0, 0, 29'h0000_0104, '0, "R11_R1_R8");
        // R1 window 1, R7 big-endian read
        access(0, 1, 29'h0800_0202, '0, "R1_R7");

        // R13 programming, R5 8-bit port, R6 wait states, R7 little-endian write
        cfg_write(2, 0, 0, 2);
        access(1, 0, 29'h1000_0010, 32'hA1B2_C3D4, "R5_R6_R7");
        // R5 16-bit port, R7 big-endian write
        cfg_write(3, 0, 1, 1);
        access(1, 1, 29'h1200_0020, 32'h1122_3344, "R5_R7");
        // R5 16-bit big-endian read on the last window
        cfg_write(5, 0, 1, 0);
        access(0, 1, 29'h1600_0008, '0, "R1_R5_R8");
        // R5 8-bit read on window 4
        cfg_write(4, 0, 0, 0);
        access(0, 0, 29'h1400_0000, '0, "R5_R8");
        // R5 width code 3 acts as 32 bits
        cfg_write(5, 0, 3, 1);
        access(0, 0, 29'h17FF_FFFC, '0, "R5");

        // R2 unmapped
        access(1, 0, 29'h1800_0000, 32'hDEAD_BEEF, "R2");
        access(0, 0, 29'h1FFF_FFFC, '0, "R2");

        // R4 protection
        cfg_write(4, 1, 2, 0);
        access(1, 0, 29'h1400_0100, 32'h5555_AAAA, "R4");
        access(0, 1, 29'h1400_0100, '0, "R4");

        // R3 combine: second large window answers on select 0 with its settings
        cfg_write(0, 0, 1, 1);
        cfg_write(1, 0, 0, 3);
        cfg_combine(1);
        access(0, 0, 29'h0800_0100, '0, "R3");
        access(1, 1, 29'h0FFF_FFF0, 32'h0F1E_2D3C, "R3");
        cfg_combine(0);
        access(0, 0, 29'h0800_0100, '0, "R1");

        // R10 setting change during a transfer
        cfg_write(2, 0, 0, 3);
        access(0, 0, 29'h1000_0040, '0, "R10");
        cfg_write(2, 0, 2, 0);
        access(0, 0, 29'h1000_0040, '0, "R10");

        // R12 back-to-back requests
        access(0, 1, 29'h0000_0000, '0, "R12");
        access(1, 0, 29'h1800_0004, 32'h1, "R12");
        access(0, 0, 29'h0000_0008, '0, "R12");

        repeat (60) @(negedge clk);
        chk(sb.size() == 0, "R12", "pending responses", 64'(sb.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule